// File: doc/BRIEF.md
# Core-Side Address Router with Region Remap

This block sits between a single 32-bit processor core and the rest of the chip and decides, for every load or store, where it goes. A request can land in one of the core's two private tightly coupled memories (TCM A and TCM B), in a fixed peripheral window served by a single-issue port, in a null target that answers with an error, or in a region translator that widens the address to 36 bits for the system interconnect.

Software moves and enables the two TCM windows and fills an eight-entry region table through a write-only register port. The decision is registered: a request accepted on one clock edge shows up on exactly one destination channel in the next cycle. It stays there until that destination acknowledges it, and the acknowledge and its error flag are passed back to the core. Only one request is in flight at a time.

Register port (`cfg_idx`, 36-bit `cfg_wdata`). Index 0 sets TCM A and index 1 sets TCM B. In both, bit 0 is the enable and bits [31:16] are the base, so the low 16 bits of a base are dropped. For region g, index 4+4g is control (bit 0 enable, bits [5:1] hold k, giving a size of 2^k bytes), index 5+4g is the 32-bit source base, and index 6+4g is the 36-bit destination base.

Top module: `core_addr_router`

## Requirements
- R1: After reset, TCM A is disabled with base 0x0000_0000, TCM B is enabled with base 0x4101_0000, `c_ready` is 1 and no destination valid is asserted.
- R2: An address whose bits [31:16] equal the base of an enabled TCM A goes to the TCM channel with `tcm_bank`=0 and `tcm_offset`=address[15:0]. When both TCM windows match, TCM A wins.
- R3: An address in an enabled TCM B window that is not in an enabled TCM A window goes to the TCM channel with `tcm_bank`=1. This holds even inside the peripheral window or the alias range.
- R4: An address outside the enabled TCM windows and inside the peripheral window goes to the peripheral port unchanged. With the default parameter the window is 0x0400_0000–0x07FF_FFFF; with the other setting it is 0x2000_0000–0x2FFF_FFFF.
- R5: An address whose bits [31:16] equal 0x7900 or 0x7902 (the core's own TCM system alias) and that no earlier rule catches goes to the null channel. The core then sees `c_resp_valid`=1 with `c_resp_err`=1 in the first cycle after acceptance.
- R6: Every other address goes to the system channel. If an enabled region matches, meaning the address and the source base agree above bit k, the lowest-numbered such region supplies the output: destination base bits above k, combined with address bits below k.
- R7: When no enabled region matches, the system address is the core address zero-extended to 36 bits.
- R8: A TCM base write keeps only bits [31:16], so the low 16 bits have no effect on decoding. Bit 0 of the same write sets the enable.
- R9: A request accepted on a clock edge appears on exactly one destination channel from the next cycle. It stays there with a stable address until that destination's ack. In the ack cycle `c_resp_valid`=1 and `c_resp_err` equals the destination's error. `c_ready` is 0 from acceptance through the ack cycle.
- R10: A disabled TCM window is not decoded, and its addresses fall to the next rule.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| c_valid | input | 1 | Core request valid |
| c_ready | output | 1 | Router can accept a request |
| c_addr | input | 32 | Core address |
| c_write | input | 1 | 1 = store, 0 = load |
| c_resp_valid | output | 1 | Response to core |
| c_resp_err | output | 1 | Response carries an error |
| cfg_we | input | 1 | Register write strobe |
| cfg_idx | input | 6 | Register index |
| cfg_wdata | input | 36 | Register write data |
| tcm_valid | output | 1 | TCM request valid |
| tcm_bank | output | 1 | 0 = TCM A, 1 = TCM B |
| tcm_offset | output | 16 | Offset within the TCM window |
| tcm_write | output | 1 | TCM store flag |
| tcm_ack | input | 1 | TCM completion |
| tcm_err | input | 1 | TCM error |
| per_valid | output | 1 | Peripheral request valid |
| per_addr | output | 32 | Peripheral address |
| per_write | output | 1 | Peripheral store flag |
| per_ack | input | 1 | Peripheral completion |
| per_err | input | 1 | Peripheral error |
| sys_valid | output | 1 | System request valid |
| sys_addr | output | 36 | Translated system address |
| sys_write | output | 1 | System store flag |
| sys_ack | input | 1 | System completion |
| sys_err | input | 1 | System error |
| null_valid | output | 1 | Null-target request (answered internally with error) |
| null_addr | output | 32 | Address sent to the null target |

## Verification
The bench moves TCM B into the peripheral window and lays TCM A over TCM B. A decoder with the wrong priority would send those hits to the peripheral port or to the wrong bank. It programs overlapping regions of different sizes, so a priority encoder that prefers the highest match, or that ignores the enable, produces a wrong 36-bit address. It also writes unaligned TCM bases, so a design that keeps the low bits would miss every hit. Alias hits must answer with an error on the first cycle, and random destination latencies check that `c_ready` stays low and the response follows the chosen destination's ack.

// File: rtl/core_addr_router.sv
module core_addr_router #(
  parameter int          REGIONS     = 8,
  parameter bit          WIDE_PERIPH = 1'b0,
  parameter logic [31:0] ATCM_ALIAS  = 32'h7900_0000,
  parameter logic [31:0] BTCM_ALIAS  = 32'h7902_0000,
  parameter int          TCM_AW      = 16,
  parameter int          IDXW        = $clog2(4 + 4*REGIONS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              c_valid,
  output logic              c_ready,
  input  logic [31:0]       c_addr,
  input  logic              c_write,
  output logic              c_resp_valid,
  output logic              c_resp_err,
  input  logic              cfg_we,
  input  logic [IDXW-1:0]   cfg_idx,
  input  logic [35:0]       cfg_wdata,
  output logic              tcm_valid,
  output logic              tcm_bank,
  output logic [TCM_AW-1:0] tcm_offset,
  output logic              tcm_write,
  input  logic              tcm_ack,
  input  logic              tcm_err,
  output logic              per_valid,
  output logic [31:0]       per_addr,
  output logic              per_write,
  input  logic              per_ack,
  input  logic              per_err,
  output logic              sys_valid,
  output logic [35:0]       sys_addr,
  output logic              sys_write,
  input  logic              sys_ack,
  input  logic              sys_err,
  output logic              null_valid,
  output logic [31:0]       null_addr
);

  localparam logic [31:0] PER_LO = WIDE_PERIPH ? 32'h2000_0000 : 32'h0400_0000;
  localparam logic [31:0] PER_HI = WIDE_PERIPH ? 32'h2FFF_FFFF : 32'h07FF_FFFF;
  localparam int          HB     = 32 - TCM_AW;
  localparam logic [31:0] B_RST  = 32'h4101_0000;

  typedef enum logic [1:0] {D_TCM, D_PER, D_NUL, D_SYS} dest_t;

  logic          a_en, b_en;
  logic [HB-1:0] a_base, b_base;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      a_en   <= 1'b0;
      a_base <= '0;
      b_en   <= 1'b1;
      b_base <= B_RST[31:TCM_AW];
    end else if (cfg_we) begin
      if (cfg_idx == IDXW'(0)) begin
        a_en   <= cfg_wdata[0];
        a_base <= cfg_wdata[31:TCM_AW];
      end
      if (cfg_idx == IDXW'(1)) begin
        b_en   <= cfg_wdata[0];
        b_base <= cfg_wdata[31:TCM_AW];
      end
    end

  logic [REGIONS-1:0] hit;
  logic [35:0]        xl [REGIONS];

  for (genvar g = 0; g < REGIONS; g++) begin : gen_region
    logic        en;
    logic [4:0]  k;
    logic [31:0] src;
    logic [35:0] dst;
    logic [31:0] msk;

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        en  <= 1'b0;
        k   <= '0;
        src <= '0;
        dst <= '0;
      end else if (cfg_we) begin
        if (cfg_idx == IDXW'(4 + 4*g)) begin
          en <= cfg_wdata[0];
          k  <= cfg_wdata[5:1];
        end
        if (cfg_idx == IDXW'(5 + 4*g)) src <= cfg_wdata[31:0];
        if (cfg_idx == IDXW'(6 + 4*g)) dst <= cfg_wdata;
      end

    assign msk    = (32'h1 << k) - 32'h1;
    assign hit[g] = en && (((c_addr ^ src) & ~msk) == 32'h0);
    assign xl[g]  = (dst & ~{4'h0, msk}) | {4'h0, c_addr & msk};
  end

  logic [35:0] xaddr;
  always_comb begin
    xaddr = {4'h0, c_addr};
    for (int i = REGIONS-1; i >= 0; i--)
      if (hit[i]) xaddr = xl[i];
  end

  logic a_hit, b_hit, p_hit, al_hit;
  assign a_hit  = a_en && (c_addr[31:TCM_AW] == a_base);
  assign b_hit  = b_en && (c_addr[31:TCM_AW] == b_base);
  assign p_hit  = (c_addr >= PER_LO) && (c_addr <= PER_HI);
  assign al_hit = (c_addr[31:TCM_AW] == ATCM_ALIAS[31:TCM_AW]) ||
                  (c_addr[31:TCM_AW] == BTCM_ALIAS[31:TCM_AW]);

  dest_t d_next;
  always_comb
    if (a_hit || b_hit) d_next = D_TCM;
    else if (p_hit)     d_next = D_PER;
    else if (al_hit)    d_next = D_NUL;
    else                d_next = D_SYS;

  logic        busy, q_bank, q_write;
  dest_t       q_dst;
  logic [35:0] q_addr;
  logic        ack_sel, err_sel;

  always_comb
    case (q_dst)
      D_TCM:   begin ack_sel = tcm_ack; err_sel = tcm_err; end
      D_PER:   begin ack_sel = per_ack; err_sel = per_err; end
      D_NUL:   begin ack_sel = 1'b1;    err_sel = 1'b1;    end
      default: begin ack_sel = sys_ack; err_sel = sys_err; end
    endcase

  assign c_ready      = !busy;
  assign c_resp_valid = busy && ack_sel;
  assign c_resp_err   = busy && ack_sel && err_sel;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      busy    <= 1'b0;
      q_dst   <= D_SYS;
      q_bank  <= 1'b0;
      q_write <= 1'b0;
      q_addr  <= '0;
    end else if (!busy) begin
      if (c_valid) begin
        busy    <= 1'b1;
        q_dst   <= d_next;
        q_bank  <= !a_hit;
        q_write <= c_write;
        q_addr  <= (d_next == D_SYS) ? xaddr : {4'h0, c_addr};
      end
    end else if (ack_sel) begin
      busy <= 1'b0;
    end

  assign tcm_valid  = busy && (q_dst == D_TCM);
  assign per_valid  = busy && (q_dst == D_PER);
  assign sys_valid  = busy && (q_dst == D_SYS);
  assign null_valid = busy && (q_dst == D_NUL);
  assign tcm_bank   = q_bank;
  assign tcm_offset = q_addr[TCM_AW-1:0];
  assign per_addr   = q_addr[31:0];
  assign null_addr  = q_addr[31:0];
  assign sys_addr   = q_addr;
  assign tcm_write  = q_write;
  assign per_write  = q_write;
  assign sys_write  = q_write;

endmodule

module core_addr_router_chk #(
  parameter bit WIDE_PERIPH = 1'b0,
  parameter int TCM_AW      = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              c_valid,
  input logic              c_ready,
  input logic              c_resp_valid,
  input logic              c_resp_err,
  input logic              tcm_valid,
  input logic              tcm_ack,
  input logic [TCM_AW-1:0] tcm_offset,
  input logic              per_valid,
  input logic [31:0]       per_addr,
  input logic              sys_valid,
  input logic              null_valid
);
  localparam logic [31:0] PER_LO = WIDE_PERIPH ? 32'h2000_0000 : 32'h0400_0000;
  localparam logic [31:0] PER_HI = WIDE_PERIPH ? 32'h2FFF_FFFF : 32'h07FF_FFFF;

  logic [3:0] vv;
  assign vv = {tcm_valid, per_valid, sys_valid, null_valid};

  // R9
  one_target_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(vv));
  // R9
  busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n) (vv != 4'h0) |-> !c_ready);
  // R9
  issue_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (c_valid && c_ready) |=> ($countones(vv) == 1));
  // R9
  resp_when_busy_chk: assert property (@(posedge clk) disable iff (!rst_n) c_resp_valid |-> (vv != 4'h0));
  // R9
  tcm_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tcm_valid && !tcm_ack) |=> (tcm_valid && $stable(tcm_offset)));
  // R5
  null_error_chk: assert property (@(posedge clk) disable iff (!rst_n)
    null_valid |-> (c_resp_valid && c_resp_err));
  // R4
  per_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    per_valid |-> ((per_addr >= PER_LO) && (per_addr <= PER_HI)));
endmodule

bind core_addr_router core_addr_router_chk #(.WIDE_PERIPH(WIDE_PERIPH), .TCM_AW(TCM_AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .c_valid(c_valid), .c_ready(c_ready),
  .c_resp_valid(c_resp_valid), .c_resp_err(c_resp_err),
  .tcm_valid(tcm_valid), .tcm_ack(tcm_ack), .tcm_offset(tcm_offset),
  .per_valid(per_valid), .per_addr(per_addr), .sys_valid(sys_valid),
  .null_valid(null_valid));

// File: tb/tb_core_addr_router.sv
`timescale 1ns/1ps
module tb_core_addr_router;
  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        c_valid = 0, c_write = 0, cfg_we = 0;
  logic [31:0] c_addr = '0;
  logic [5:0]  cfg_idx = '0;
  logic [35:0] cfg_wdata = '0;
  logic        tcm_ack = 0, tcm_err = 0, per_ack = 0, per_err = 0, sys_ack = 0, sys_err = 0;
  logic        c_ready, c_resp_valid, c_resp_err;
  logic        tcm_valid, tcm_bank, tcm_write, per_valid, per_write, sys_valid, sys_write, null_valid;
  logic [15:0] tcm_offset;
  logic [31:0] per_addr, null_addr;
  logic [35:0] sys_addr;

  core_addr_router dut (.*);

  int checks = 0, errors = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input logic [35:0] act, input logic [35:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  logic        m_aen = 0, m_ben = 1;
  logic [15:0] m_abase = 16'h0000, m_bbase = 16'h4101;
  logic        m_ren [8];
  logic [4:0]  m_k   [8];
  logic [31:0] m_src [8];
  logic [35:0] m_dst [8];
  initial for (int i = 0; i < 8; i++) begin m_ren[i] = 0; m_k[i] = 0; m_src[i] = 0; m_dst[i] = 0; end

  // dest codes: 0 TCM, 1 peripheral, 2 null, 3 system
  function automatic void route(input logic [31:0] a, output int d, output logic [35:0] x, output bit bank);
    logic [31:0] m;
    x = {4'h0, a}; bank = 0;
    if (m_aen && a[31:16] == m_abase) d = 0;
    else if (m_ben && a[31:16] == m_bbase) begin d = 0; bank = 1; end
    else if (a >= 32'h0400_0000 && a <= 32'h07FF_FFFF) d = 1;
    else if (a[31:16] == 16'h7900 || a[31:16] == 16'h7902) d = 2;
    else begin
      d = 3;
      for (int i = 7; i >= 0; i--) begin
        m = (32'h1 << m_k[i]) - 1;
        if (m_ren[i] && ((a ^ m_src[i]) & ~m) == 0)
          x = (m_dst[i] & ~{4'h0, m}) | {4'h0, a & m};
      end
    end
  endfunction

  task automatic cfg(input int idx, input logic [35:0] v);
    @(negedge clk); cfg_we = 1; cfg_idx = 6'(idx); cfg_wdata = v;
    @(negedge clk); cfg_we = 0;
    if (idx == 0) begin m_aen = v[0]; m_abase = v[31:16]; end
    else if (idx == 1) begin m_ben = v[0]; m_bbase = v[31:16]; end
    else if (idx >= 4 && idx < 36) begin
      case (idx % 4)
        0: begin m_ren[idx/4-1] = v[0]; m_k[idx/4-1] = v[5:1]; end
        1: m_src[idx/4-1] = v[31:0];
        2: m_dst[idx/4-1] = v;
        default: ;
      endcase
    end
  endtask

  task automatic region(input int g, input bit en, input int k, input logic [31:0] s, input logic [35:0] dd);
    cfg(5 + 4*g, {4'h0, s});
    cfg(6 + 4*g, dd);
    cfg(4 + 4*g, {30'h0, 5'(k), en});
  endtask

  task automatic access(input logic [31:0] a, input string req, input int lat, input bit err);
    int d, got; logic [35:0] x; bit bank; logic [35:0] act;
    route(a, d, x, bank);
    @(negedge clk);
    chk(c_ready, "R9", {35'h0, c_ready}, 36'h1);
    c_valid = 1; c_addr = a; c_write = a[2];
    @(negedge clk); c_valid = 0;
    got = tcm_valid ? 0 : per_valid ? 1 : null_valid ? 2 : sys_valid ? 3 : 7;
    chk((tcm_valid + per_valid + null_valid + sys_valid) == 1 && got == d, req, 36'(got), 36'(d));
    case (d)
      0: act = {19'h0, tcm_bank, tcm_offset};
      1: act = {4'h0, per_addr};
      2: act = {4'h0, null_addr};
      default: act = sys_addr;
    endcase
    if (d == 0) chk(act == {19'h0, bank, a[15:0]}, req, act, {19'h0, bank, a[15:0]});
    else        chk(act == x, req, act, x);
    if (d == 2) begin
      chk(c_resp_valid && c_resp_err, "R5", {34'h0, c_resp_valid, c_resp_err}, 36'h3);
      @(negedge clk);
    end else begin
      repeat (lat) @(negedge clk);
      chk(!c_ready && !c_resp_valid, "R9", {34'h0, c_ready, c_resp_valid}, 36'h0);
      case (d) 0: begin tcm_ack = 1; tcm_err = err; end
               1: begin per_ack = 1; per_err = err; end
               default: begin sys_ack = 1; sys_err = err; end
      endcase
      #1;
      chk(c_resp_valid && c_resp_err == err, "R9", {34'h0, c_resp_valid, c_resp_err}, {34'h0, 1'b1, err});
      @(negedge clk);
      tcm_ack = 0; per_ack = 0; sys_ack = 0; tcm_err = 0; per_err = 0; sys_err = 0;
    end
  endtask

  initial begin
    #(4*150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(c_ready && !tcm_valid && !per_valid && !sys_valid && !null_valid, "R1",
        {31'h0, c_ready, tcm_valid, per_valid, sys_valid, null_valid}, 36'h10);
    access(32'h4101_0040, "R1", 1, 0);
    access(32'h0000_1234, "R10", 0, 0);   // TCM A disabled -> system, R7 zero-extended
    access(32'h8000_0010, "R7", 2, 1);
    access(32'h7900_0010, "R5", 0, 0);
    access(32'h7902_FFFC, "R5", 0, 0);
    access(32'h07FE_0000, "R4", 1, 1);
    access(32'h0400_0000, "R4", 0, 0);
    access(32'h0800_0000, "R4", 0, 0);
    cfg(0, 36'h0_4101_1235);               // R8 unaligned base, enable
    access(32'h4101_0100, "R2", 0, 0);     // overlap: TCM A wins
    access(32'h4101_FFFF, "R8", 1, 0);
    cfg(1, 36'h0_0500_0001);
    access(32'h0500_0020, "R3", 0, 1);     // TCM B inside peripheral window
    cfg(0, 36'h0_7900_0001);
    access(32'h7900_0008, "R2", 0, 0);     // TCM A over alias
    cfg(0, 36'h0_7900_0000);
    access(32'h7900_0008, "R10", 0, 0);
    region(0, 1, 20, 32'h8000_0000, 36'h9_0000_0000);
    region(1, 1, 28, 32'h8000_0000, 36'h1_2000_0000);
    region(2, 0, 24, 32'hC000_0000, 36'hA_0000_0000);
    access(32'h8000_1234, "R6", 0, 0);
    access(32'h8010_0004, "R6", 1, 0);
    access(32'hC000_0040, "R7", 0, 0);
    for (int n = 0; n < 400; n++) begin
      logic [31:0] a; int c;
      if ($urandom_range(0, 9) == 0) begin
        case ($urandom_range(0, 2))
          0: cfg(0, {4'h0, $urandom()});
          1: cfg(1, {4'h0, $urandom()});
          default: region($urandom_range(0, 7), $urandom_range(0, 3) != 0, $urandom_range(12, 31),
                          32'h8000_0000 | $urandom(), {$urandom_range(0, 15), $urandom()});
        endcase
      end
      c = $urandom_range(0, 5);
      case (c)
        0: a = $urandom();
        1: a = {($urandom_range(0, 1) ? m_abase : m_bbase), 16'($urandom())};
        2: a = 32'h0400_0000 + $urandom_range(0, 32'h03FF_FFFF);
        3: a = {($urandom_range(0, 1) ? 16'h7900 : 16'h7902), 16'($urandom())} ^ {31'h0, $urandom_range(0, 1) == 0 ? 1'b0 : 1'b0};
        4: a = m_src[$urandom_range(0, 7)] ^ 32'($urandom_range(0, 32'hFFFF));
        default: a = 32'h8000_0000 | $urandom();
      endcase
      access(a, c == 3 ? "R5" : (c >= 4 ? "R6" : "R4"), $urandom_range(0, 3), $urandom_range(0, 1));
    end
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule